// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Condition Flags

This block is the data path of a small accumulator-style processor. In one combinational pass it takes an accumulator operand, a second operand (a register-file byte or an immediate), the incoming carry and digit-carry, and an operation code. It returns the 8-bit result, a candidate value for each of five condition flags, and a mask that says which flags the operation is allowed to change. An unsigned multiply returns a full 16-bit product on its own output.

The five flags are kept in a status register inside the block. On a cycle where `commit_i` is high, each flag whose mask bit is set takes its candidate value, and every other flag keeps its value. Choosing where the result goes, decoding instructions and accessing memory belong to the surrounding core. The carry and digit-carry inputs are separate ports, so the core can feed back the stored flags or any other value.

Top module: `alu8_core`

## Requirements
- R1: Flag vectors (`flag_next_o`, `flag_upd_o`, `status_o`) use bit 0 = carry C, bit 1 = digit carry DC, bit 2 = zero Z, bit 3 = overflow OV, bit 4 = negative N. Whenever N or Z may be updated, N equals bit 7 of the result and Z is 1 exactly when the 8-bit result is 0.
- R2: Opcode 0 gives acc+opb and opcode 1 gives acc+opb+cin. C is the carry out of bit 7, DC is the carry out of bit 3, and OV is set when the two operands have the same sign and the result has the other sign. All five flags update. Example: 0x9F+0x52 = 0xF1 with N=1, OV=0, Z=0, DC=1, C=0.
- R3: Opcode 2 gives opb-acc and opcode 4 gives acc-opb. Opcodes 3 and 5 do the same subtractions and take away one more when cin is 1. C is 1 when a borrow comes out of bit 7 and DC is 1 when a borrow comes out of bit 3. OV is the signed overflow. All five flags update.
- R4: Opcode 6 gives opb+1, opcode 7 gives opb-1 and opcode 9 gives 0-opb. Their flags follow the addition rules (opcode 6) or the subtraction rules (opcodes 7 and 9), and all five flags update.
- R5: Opcode 8 gives ~opb, and opcodes 10, 11 and 12 give acc AND, OR and XOR opb. They update only N and Z (mask 5'b10100).
- R6: Opcodes 13 and 15 rotate opb left or right through the carry. The old cin enters the vacated bit, the bit shifted out becomes C, and the mask is 5'b10101. Opcodes 14 and 16 rotate opb left or right within eight bits with mask 5'b10100.
- R7: Opcode 17 swaps the two nibbles of opb and updates no flag.
- R8: Opcode 18 decimal-adjusts acc. It first adds 0x06 when the low nibble is above 9 or dcin is 1. It then adds 0x60 when that first step carried out, the high nibble is now above 9, or cin is 1. C becomes cin OR any carry out of bit 7. The mask is 5'b10101.
- R9: Opcode 19 forms the unsigned 16-bit product acc*opb on `product_o`. The result is its low byte and the mask is zero.
- R10: `status_o` is 0 after reset. On a clock edge with `commit_i` high, each flag with its mask bit set loads its candidate value, and the others hold. With `commit_i` low, all flags hold.
- R11: Opcodes 20 to 31 give result 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code (R2 to R11) |
| acc_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | File or literal operand |
| cin_i | input | 1 | Incoming carry/borrow |
| dcin_i | input | 1 | Incoming digit carry, used by decimal adjust |
| commit_i | input | 1 | Load masked flags into the status register |
| result_o | output | 8 | Operation result |
| product_o | output | 16 | Unsigned product |
| flag_next_o | output | 5 | Candidate flag values |
| flag_upd_o | output | 5 | Per-flag update mask |
| status_o | output | 5 | Registered flags |

## Verification
Two things can happen in the same cycle. The status register commits the flags of one operation while the combinational path is already producing the next, possibly flag-preserving, operation such as a multiply or a nibble swap. The bench commits an addition, then commits a multiply and a swap, then a masked logic operation. After each clock edge it checks that the status register holds exactly the expected flags. The flags outside the mask must keep the previous operation's values, while the product and result of the later operation are correct.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NB    = DW / 2;
  localparam int PW    = 2 * DW;
  localparam int NFLG  = 5;
  localparam int OPW   = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD    = 5'd0,
    OP_ADDC   = 5'd1,
    OP_SUBBA  = 5'd2,
    OP_SUBBAB = 5'd3,
    OP_SUBAB  = 5'd4,
    OP_SUBABB = 5'd5,
    OP_INC    = 5'd6,
    OP_DEC    = 5'd7,
    OP_COM    = 5'd8,
    OP_NEG    = 5'd9,
    OP_AND    = 5'd10,
    OP_IOR    = 5'd11,
    OP_XOR    = 5'd12,
    OP_ROLC   = 5'd13,
    OP_ROL    = 5'd14,
    OP_RORC   = 5'd15,
    OP_ROR    = 5'd16,
    OP_SWAP   = 5'd17,
    OP_DECADJ = 5'd18,
    OP_MUL    = 5'd19
  } alu_op_e;

  localparam logic [NFLG-1:0] UPD_ALL  = 5'b11111;
  localparam logic [NFLG-1:0] UPD_NZ   = 5'b10100;
  localparam logic [NFLG-1:0] UPD_NZC  = 5'b10101;
  localparam logic [NFLG-1:0] UPD_NONE = 5'b00000;
endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         xin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         dc_o,
  output logic         ov_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [HW:0]   half;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~xin_i : xin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    half  = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
    sum_o = full[W-1:0];
    c_o   = sub_i ? ~full[W] : full[W];
    dc_o  = sub_i ? ~half[HW] : half[HW];
    ov_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opb_i,
  input  logic           cin_i,
  output logic [DW-1:0]  res_o,
  output logic           cout_o
);
  always_comb begin
    res_o  = '0;
    cout_o = cin_i;
    case (op_i)
      OP_COM:  res_o = ~opb_i;
      OP_AND:  res_o = acc_i & opb_i;
      OP_IOR:  res_o = acc_i | opb_i;
      OP_XOR:  res_o = acc_i ^ opb_i;
      OP_ROLC: begin
        res_o  = {opb_i[DW-2:0], cin_i};
        cout_o = opb_i[DW-1];
      end
      OP_ROL:  res_o = {opb_i[DW-2:0], opb_i[DW-1]};
      OP_RORC: begin
        res_o  = {cin_i, opb_i[DW-1:1]};
        cout_o = opb_i[0];
      end
      OP_ROR:  res_o = {opb_i[0], opb_i[DW-1:1]};
      OP_SWAP: res_o = {opb_i[NB-1:0], opb_i[DW-1:NB]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] acc_i,
  input  logic          cin_i,
  input  logic          dcin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  localparam logic [NB-1:0] DIGIT_MAX = NB'(9);
  localparam logic [DW-1:0] LO_FIX    = DW'(6);
  localparam logic [DW-1:0] HI_FIX    = DW'(6) << NB;

  logic [DW:0] step1;
  logic [DW:0] step2;
  logic        lo_need;
  logic        hi_need;

  always_comb begin
    lo_need = (acc_i[NB-1:0] > DIGIT_MAX) || dcin_i;
    step1   = {1'b0, acc_i} + (lo_need ? {1'b0, LO_FIX} : '0);
    hi_need = step1[DW] || (step1[DW-1:NB] > DIGIT_MAX) || cin_i;
    step2   = {1'b0, step1[DW-1:0]} + (hi_need ? {1'b0, HI_FIX} : '0);
    res_o   = step2[DW-1:0];
    cout_o  = cin_i | step1[DW] | step2[DW];
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic [NFLG-1:0] upd_i,
  input  logic [NFLG-1:0] nxt_i,
  output logic [NFLG-1:0] q_o
);
  logic [NFLG-1:0] q_d;

  for (genvar g = 0; g < NFLG; g++) begin : g_bit
    always_comb q_d[g] = (commit_i && upd_i[g]) ? nxt_i[g] : q_o[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      op_i,
  input  logic [7:0]      acc_i,
  input  logic [7:0]      opb_i,
  input  logic            cin_i,
  input  logic            dcin_i,
  input  logic            commit_i,
  output logic [7:0]      result_o,
  output logic [15:0]     product_o,
  output logic [4:0]      flag_next_o,
  output logic [4:0]      flag_upd_o,
  output logic [4:0]      status_o
);
  logic          rst_core_n;
  logic [DW-1:0] as_a, as_b, as_sum, bo_res, da_res;
  logic          as_sub, as_xin, as_c, as_dc, as_ov, bo_c, da_c;
  logic          is_arith;
  logic          c_sel;

  alu8_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    as_a     = acc_i;
    as_b     = opb_i;
    as_sub   = 1'b0;
    as_xin   = 1'b0;
    is_arith = 1'b1;
    case (op_i)
      OP_ADD:    ;
      OP_ADDC:   as_xin = cin_i;
      OP_SUBBA:  begin as_a = opb_i; as_b = acc_i; as_sub = 1'b1; end
      OP_SUBBAB: begin as_a = opb_i; as_b = acc_i; as_sub = 1'b1; as_xin = cin_i; end
      OP_SUBAB:  as_sub = 1'b1;
      OP_SUBABB: begin as_sub = 1'b1; as_xin = cin_i; end
      OP_INC:    begin as_a = opb_i; as_b = '0; as_xin = 1'b1; end
      OP_DEC:    begin as_a = opb_i; as_b = DW'(1); as_sub = 1'b1; end
      OP_NEG:    begin as_a = '0; as_b = opb_i; as_sub = 1'b1; end
      default:   is_arith = 1'b0;
    endcase
  end

  alu8_addsub #(.W(DW)) u_addsub (
    .a_i   (as_a),
    .b_i   (as_b),
    .sub_i (as_sub),
    .xin_i (as_xin),
    .sum_o (as_sum),
    .c_o   (as_c),
    .dc_o  (as_dc),
    .ov_o  (as_ov)
  );

  alu8_bitops u_bitops (
    .op_i   (op_i),
    .acc_i  (acc_i),
    .opb_i  (opb_i),
    .cin_i  (cin_i),
    .res_o  (bo_res),
    .cout_o (bo_c)
  );

  alu8_decadj u_decadj (
    .acc_i  (acc_i),
    .cin_i  (cin_i),
    .dcin_i (dcin_i),
    .res_o  (da_res),
    .cout_o (da_c)
  );

  always_comb product_o = PW'(acc_i) * PW'(opb_i);

  always_comb begin
    c_sel = bo_c;
    if (is_arith) begin
      result_o   = as_sum;
      c_sel      = as_c;
      flag_upd_o = UPD_ALL;
    end else begin
      case (op_i)
        OP_COM, OP_AND, OP_IOR, OP_XOR, OP_ROL, OP_ROR: begin
          result_o   = bo_res;
          flag_upd_o = UPD_NZ;
        end
        OP_ROLC, OP_RORC: begin
          result_o   = bo_res;
          flag_upd_o = UPD_NZC;
        end
        OP_SWAP: begin
          result_o   = bo_res;
          flag_upd_o = UPD_NONE;
        end
        OP_DECADJ: begin
          result_o   = da_res;
          c_sel      = da_c;
          flag_upd_o = UPD_NZC;
        end
        OP_MUL: begin
          result_o   = product_o[DW-1:0];
          flag_upd_o = UPD_NONE;
        end
        default: begin
          result_o   = '0;
          flag_upd_o = UPD_NONE;
        end
      endcase
    end
    flag_next_o         = '0;
    flag_next_o[FLG_C]  = c_sel;
    flag_next_o[FLG_DC] = as_dc;
    flag_next_o[FLG_OV] = as_ov;
    flag_next_o[FLG_Z]  = (result_o == '0);
    flag_next_o[FLG_N]  = result_o[DW-1];
  end

  alu8_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit_i (commit_i),
    .upd_i    (flag_upd_o),
    .nxt_i    (flag_next_o),
    .q_o      (status_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  op_i,
  input logic        commit_i,
  input logic [7:0]  result_o,
  input logic [15:0] product_o,
  input logic [4:0]  flag_next_o,
  input logic [4:0]  flag_upd_o,
  input logic [4:0]  status_o
);
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(status_o));

  for (genvar g = 0; g < 5; g++) begin : g_flag
    // R10
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && flag_upd_o[g]) |=> (status_o[g] == $past(flag_next_o[g])));
    // R10
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !flag_upd_o[g]) |=> $stable(status_o[g]));
  end

  // R9
  mul_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd19) |-> (flag_upd_o == 5'b00000 && result_o == product_o[7:0]));

  // R7
  swap_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd17) |-> (flag_upd_o == 5'b00000));

  // R11
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 5'd19) |-> (result_o == 8'h00 && flag_upd_o == 5'b00000));

  // R1
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd_o[2] |-> (flag_next_o[2] == (result_o == 8'h00)));
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .commit_i    (commit_i),
  .result_o    (result_o),
  .product_o   (product_o),
  .flag_next_o (flag_next_o),
  .flag_upd_o  (flag_upd_o),
  .status_o    (status_o)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op_i;
  logic [7:0]  acc_i, opb_i;
  logic        cin_i, dcin_i, commit_i;
  logic [7:0]  result_o;
  logic [15:0] product_o;
  logic [4:0]  flag_next_o, flag_upd_o, status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opb_i(opb_i),
    .cin_i(cin_i), .dcin_i(dcin_i), .commit_i(commit_i), .result_o(result_o),
    .product_o(product_o), .flag_next_o(flag_next_o), .flag_upd_o(flag_upd_o),
    .status_o(status_o)
  );

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flags: bit0 C, bit1 DC, bit2 Z, bit3 OV, bit4 N
  task automatic run_op(input string tag, input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic ci, input logic dci,
                        input logic [7:0] exp_res, input logic [4:0] exp_upd,
                        input logic [4:0] exp_flg);
    @(negedge clk);
    op_i = op; acc_i = a; opb_i = b; cin_i = ci; dcin_i = dci; commit_i = 1'b0;
    #1;
    cmp({tag, " result"}, {8'h00, result_o}, {8'h00, exp_res});
    cmp({tag, " mask"}, {11'h0, flag_upd_o}, {11'h0, exp_upd});
    cmp({tag, " flags"}, {11'h0, flag_next_o & exp_upd}, {11'h0, exp_flg & exp_upd});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_i = '0; acc_i = '0; opb_i = '0; cin_i = 0; dcin_i = 0; commit_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R10 reset status", {11'h0, status_o}, 16'h0);
  endtask

  task automatic t_add();
    run_op("R2 add 9F+52", 5'd0, 8'h9F, 8'h52, 0, 0, 8'hF1, 5'b11111, 5'b10010);
    run_op("R2 add 7F+01 ov", 5'd0, 8'h7F, 8'h01, 0, 0, 8'h80, 5'b11111, 5'b11010);
    run_op("R2 addc FF+00+1", 5'd1, 8'hFF, 8'h00, 1, 0, 8'h00, 5'b11111, 5'b00111);
    run_op("R1 add zero", 5'd0, 8'h80, 8'h80, 0, 0, 8'h00, 5'b11111, 5'b01101);
  endtask

  task automatic t_sub();
    run_op("R3 opb-acc borrow", 5'd2, 8'h20, 8'h10, 0, 0, 8'hF0, 5'b11111, 5'b10001);
    run_op("R3 acc-opb", 5'd4, 8'h20, 8'h10, 0, 0, 8'h10, 5'b11111, 5'b00000);
    run_op("R3 opb-acc-b ov", 5'd3, 8'h00, 8'h80, 1, 0, 8'h7F, 5'b11111, 5'b01010);
    run_op("R3 acc-opb-b zero", 5'd5, 8'h05, 8'h05, 0, 0, 8'h00, 5'b11111, 5'b00100);
  endtask

  task automatic t_incdec();
    run_op("R4 inc FF", 5'd6, 8'h00, 8'hFF, 0, 0, 8'h00, 5'b11111, 5'b00111);
    run_op("R4 dec 00", 5'd7, 8'h00, 8'h00, 0, 0, 8'hFF, 5'b11111, 5'b10011);
    run_op("R4 dec 80", 5'd7, 8'h00, 8'h80, 0, 0, 8'h7F, 5'b11111, 5'b01010);
    run_op("R4 neg 80", 5'd9, 8'h00, 8'h80, 0, 0, 8'h80, 5'b11111, 5'b11001);
    run_op("R4 neg 00", 5'd9, 8'h33, 8'h00, 0, 0, 8'h00, 5'b11111, 5'b00100);
  endtask

  task automatic t_logic();
    run_op("R5 com", 5'd8, 8'h00, 8'hF0, 1, 1, 8'h0F, 5'b10100, 5'b00000);
    run_op("R5 and", 5'd10, 8'hF0, 8'h0F, 0, 0, 8'h00, 5'b10100, 5'b00100);
    run_op("R5 ior", 5'd11, 8'h80, 8'h01, 0, 0, 8'h81, 5'b10100, 5'b10000);
    run_op("R5 xor", 5'd12, 8'hAA, 8'hAA, 0, 0, 8'h00, 5'b10100, 5'b00100);
  endtask

  task automatic t_rot();
    run_op("R6 rolc", 5'd13, 8'h00, 8'h81, 0, 0, 8'h02, 5'b10101, 5'b00001);
    run_op("R6 rorc", 5'd15, 8'h00, 8'h01, 1, 0, 8'h80, 5'b10101, 5'b10001);
    run_op("R6 rol", 5'd14, 8'h00, 8'h81, 0, 0, 8'h03, 5'b10100, 5'b00000);
    run_op("R6 ror", 5'd16, 8'h00, 8'h01, 0, 0, 8'h80, 5'b10100, 5'b10000);
    run_op("R7 swap", 5'd17, 8'h00, 8'h3C, 1, 1, 8'hC3, 5'b00000, 5'b00000);
  endtask

  task automatic t_decadj();
    run_op("R8 adj 3C", 5'd18, 8'h3C, 8'h00, 0, 0, 8'h42, 5'b10101, 5'b00000);
    run_op("R8 adj 9A", 5'd18, 8'h9A, 8'h00, 0, 0, 8'h00, 5'b10101, 5'b00101);
    run_op("R8 adj 22 dc", 5'd18, 8'h22, 8'h00, 0, 1, 8'h28, 5'b10101, 5'b00000);
    run_op("R8 adj 12 c", 5'd18, 8'h12, 8'h00, 1, 0, 8'h72, 5'b10101, 5'b00001);
    run_op("R8 adj 99", 5'd18, 8'h99, 8'h00, 0, 0, 8'h99, 5'b10101, 5'b10000);
  endtask

  task automatic t_mul();
    run_op("R9 mul FFxFF", 5'd19, 8'hFF, 8'hFF, 0, 0, 8'h01, 5'b00000, 5'b00000);
    cmp("R9 product FFxFF", product_o, 16'hFE01);
    run_op("R9 mul 0Cx0A", 5'd19, 8'h0C, 8'h0A, 0, 0, 8'h78, 5'b00000, 5'b00000);
    cmp("R9 product 0Cx0A", product_o, 16'h0078);
    run_op("R11 undefined", 5'd25, 8'hFF, 8'hFF, 1, 1, 8'h00, 5'b00000, 5'b00000);
  endtask

  task automatic commit_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic ci, input logic en);
    @(negedge clk);
    op_i = op; acc_i = a; opb_i = b; cin_i = ci; dcin_i = 0; commit_i = en;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic t_status();
    commit_op(5'd0, 8'h9F, 8'h52, 0, 1);
    cmp("R10 commit add", {11'h0, status_o}, 16'h0012);
    commit_op(5'd19, 8'h00, 8'h00, 0, 1);
    cmp("R10 commit mul keeps", {11'h0, status_o}, 16'h0012);
    commit_op(5'd17, 8'h00, 8'h00, 0, 1);
    cmp("R10 commit swap keeps", {11'h0, status_o}, 16'h0012);
    commit_op(5'd10, 8'h0F, 8'hF0, 0, 1);
    cmp("R10 masked and", {11'h0, status_o}, 16'h0006);
    commit_op(5'd0, 8'h7F, 8'h01, 0, 0);
    cmp("R10 no commit holds", {11'h0, status_o}, 16'h0006);
    commit_op(5'd13, 8'h00, 8'h80, 0, 1);
    cmp("R10 rolc carry", {11'h0, status_o}, 16'h0007);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_incdec();
    t_logic();
    t_rot();
    t_decadj();
    t_mul();
    t_status();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule